// File: doc/BRIEF.md
# Bootstrap Memory Copy Engine

The block keeps a small bootstrap program in a local memory that stays powered while the rest of the processor sleeps. On request it copies a programmed run of 32-bit words from that memory into the processor's instruction memory. It writes one word per clock through a plain write port.

Software sets a source word index, a destination word address and a word count, then sets the go bit in the control word. It learns that the copy has finished by polling until the go bit reads back as 0. If software has also set the arm bit, every later power-up event repeats the same copy with no software action. The block also holds two image pointers and two image lengths for a later loader stage. The write that sets the top bit of the instruction length raises a one-cycle load request.

The copy sequencer has three states:
- SEQ_IDLE: waiting for a request.
- SEQ_PRIME: the first bootstrap word is being fetched.
- SEQ_STREAM: one word is written per cycle while the next one is fetched.

Its transitions are:
- SEQ_IDLE to SEQ_PRIME on a request with a nonzero count.
- SEQ_IDLE to SEQ_IDLE on a request with a zero count. Done is set and nothing is written.
- SEQ_PRIME to SEQ_STREAM, always after one cycle.
- SEQ_STREAM to SEQ_STREAM while more than one word remains.
- SEQ_STREAM to SEQ_IDLE on the last word. Done is set in the same cycle.

Top module: `boot_copy_engine`

## Requirements
- R1: The bootstrap memory holds 256 words. It is written and read over the register bus at byte offsets 0x400 to 0x7FC, and word i sits at 0x400 + 4*i. `reg_rdata` shows the value at the address presented in the previous cycle.
- R2: The control word is at offset 0x0. Bit 31 is go and bit 30 is arm. Writing go=1 while idle copies count words, with the source word index at 0x4, the destination word address at 0x8 and the count at 0xC.
- R3: The copy writes one word in each consecutive cycle. Source and destination each advance by one per word, and the source index wraps modulo 256.
- R4: Go reads 1 from the cycle after a copy starts until its last word is written, and 0 afterwards. Status bit 0 at offset 0x10 reads 0 while a copy with a nonzero count runs and 1 once it has finished.
- R5: A count of zero sets status bit 0 at once, performs no write, and leaves go reading 0.
- R6: Writes to offsets 0x4, 0x8 and 0xC while a copy runs are ignored. Read-back and later copies keep the earlier values.
- R7: A one-cycle `pwr_up` pulse starts the programmed copy when arm is 1 and no copy is running. It has no effect when arm is 0 or a copy is already running.
- R8: Offsets 0x90 and 0x98 hold 32-bit instruction and data image pointers, and 0x9C holds a 32-bit data length. Offset 0x94 holds the instruction length in bits 30:0, with bit 31 reading 0. All four drive the matching outputs.
- R9: A write to 0x94 with bit 31 set raises `load_req` for exactly the one cycle after the write. A write with bit 31 clear raises nothing.
- R10: After reset all registers read 0, `imem_we` and `load_req` are 0, and status bit 0 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_up | input | 1 | Power-up event pulse |
| reg_we | input | 1 | Register bus write strobe |
| reg_addr | input | 12 | Register bus byte offset |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Registered read data |
| imem_we | output | 1 | Instruction memory write enable |
| imem_addr | output | 12 | Instruction memory word address |
| imem_wdata | output | 32 | Instruction memory write data |
| load_req | output | 1 | One-cycle loader start request |
| inst_ptr | output | 32 | Instruction image pointer |
| inst_len | output | 31 | Instruction image length |
| data_ptr | output | 32 | Data image pointer |
| data_len | output | 32 | Data image length |

## Verification
The bench builds the block with its default values: 256 bootstrap words, a 12-bit instruction address and a 12-bit bus offset. With these values a count of 256 is the largest copy, and it walks the whole bootstrap memory. A source index of 250 reaches the wrap back to word 0 within a ten-word copy. The 12-bit destination range lets each scenario write to its own region, so stray or overrunning writes show up as nonzero words in a bench-side model that should have stayed clear.

// File: rtl/boot_copy_pkg.sv
package boot_copy_pkg;

    localparam int WORD_W = 32;

    localparam int OFS_CTRL = 'h000;
    localparam int OFS_SRC  = 'h004;
    localparam int OFS_DST  = 'h008;
    localparam int OFS_CNT  = 'h00C;
    localparam int OFS_STAT = 'h010;
    localparam int OFS_IPTR = 'h090;
    localparam int OFS_ILEN = 'h094;
    localparam int OFS_DPTR = 'h098;
    localparam int OFS_DLEN = 'h09C;

    localparam int BIT_GO   = 31;
    localparam int BIT_ARM  = 30;
    localparam int BIT_LREQ = 31;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_PRIME  = 2'd1,
        SEQ_STREAM = 2'd2
    } seq_state_t;

endpackage

// File: rtl/boot_store.sv
module boot_store
    import boot_copy_pkg::*;
#(
    parameter int WORDS = 256,
    parameter int AW    = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              bus_we,
    input  logic [AW-1:0]     bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_q,
    input  logic [AW-1:0]     eng_addr,
    output logic [WORD_W-1:0] eng_q
);

    logic [WORD_W-1:0] mem [WORDS];

    // Bus port: read-first, write-through is not needed by any caller.
    always_ff @(posedge clk) begin
        if (bus_we) begin
            mem[bus_addr] <= bus_wdata;
        end
        bus_q <= mem[bus_addr];
    end

    // Engine port: read-only, one cycle latency.
    always_ff @(posedge clk) begin
        eng_q <= mem[eng_addr];
    end

endmodule

// File: rtl/copy_sequencer.sv
module copy_sequencer
    import boot_copy_pkg::*;
#(
    parameter int SRC_AW = 8,
    parameter int DST_AW = 12,
    parameter int CNT_W  = SRC_AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [SRC_AW-1:0] src_base,
    input  logic [DST_AW-1:0] dst_base,
    input  logic [CNT_W-1:0]  count,
    input  logic [WORD_W-1:0] rd_q,
    output logic              busy,
    output logic              done,
    output logic [SRC_AW-1:0] rd_addr,
    output logic              wr_en,
    output logic [DST_AW-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data
);

    seq_state_t        state_q, state_d;
    logic [SRC_AW-1:0] src_q;
    logic [DST_AW-1:0] dst_q;
    logic [CNT_W-1:0]  left_q;
    logic              done_q;
    logic              last_word;

    assign last_word = (left_q == CNT_W'(1));

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE: begin
                if (go && (count != '0)) begin
                    state_d = SEQ_PRIME;
                end
            end
            SEQ_PRIME: begin
                state_d = SEQ_STREAM;
            end
            SEQ_STREAM: begin
                if (last_word) begin
                    state_d = SEQ_IDLE;
                end
            end
            default: begin
                state_d = SEQ_IDLE;
            end
        endcase
    end

    // Address, count and completion datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            dst_q  <= '0;
            left_q <= '0;
            done_q <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (go) begin
                        if (count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            done_q <= 1'b0;
                            src_q  <= src_base;
                            dst_q  <= dst_base;
                            left_q <= count;
                        end
                    end
                end
                SEQ_PRIME: begin
                    src_q <= src_q + 1'b1;
                end
                SEQ_STREAM: begin
                    src_q  <= src_q + 1'b1;
                    dst_q  <= dst_q + 1'b1;
                    left_q <= left_q - 1'b1;
                    if (last_word) begin
                        done_q <= 1'b1;
                    end
                end
                default: begin
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy    = (state_q != SEQ_IDLE);
        done    = done_q;
        rd_addr = src_q;
        wr_en   = (state_q == SEQ_STREAM);
        wr_addr = dst_q;
        wr_data = rd_q;
    end

    // R3: successive writes land on successive destination words
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == DST_AW'($past(wr_addr) + 1'b1)));

    // R5: an empty request completes without leaving idle
    assert_zero_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_IDLE && go && count == '0) |=> (!busy && done));

    // R4: completion is never reported while words are still moving
    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: rtl/image_regs.sv
module image_regs
    import boot_copy_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] inst_ptr,
    output logic [WORD_W-2:0] inst_len,
    output logic [WORD_W-1:0] data_ptr,
    output logic [WORD_W-1:0] data_len,
    output logic              load_req
);

    logic hit_ilen;
    assign hit_ilen = wr_en && (wr_addr == AW'(OFS_ILEN));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inst_ptr <= '0;
            inst_len <= '0;
            data_ptr <= '0;
            data_len <= '0;
            load_req <= 1'b0;
        end else begin
            load_req <= hit_ilen && wr_data[BIT_LREQ];
            if (wr_en) begin
                if (wr_addr == AW'(OFS_IPTR)) inst_ptr <= wr_data;
                if (wr_addr == AW'(OFS_DPTR)) data_ptr <= wr_data;
                if (wr_addr == AW'(OFS_DLEN)) data_len <= wr_data;
            end
            if (hit_ilen) begin
                inst_len <= wr_data[WORD_W-2:0];
            end
        end
    end

    // R9: a load request always carries the length written with it
    assert_len_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> (inst_len == $past(wr_data[WORD_W-2:0])));

endmodule

// File: rtl/boot_copy_engine.sv
module boot_copy_engine
    import boot_copy_pkg::*;
#(
    parameter int MEM_WORDS = 256,
    parameter int IMEM_AW   = 12,
    parameter int BUS_AW    = 12,
    parameter int MEM_BASE  = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_up,
    input  logic              reg_we,
    input  logic [BUS_AW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              imem_we,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [31:0]       imem_wdata,
    output logic              load_req,
    output logic [31:0]       inst_ptr,
    output logic [30:0]       inst_len,
    output logic [31:0]       data_ptr,
    output logic [31:0]       data_len
);

    localparam int SRC_AW = $clog2(MEM_WORDS);
    localparam int CNT_W  = SRC_AW + 1;

    // Address decode
    logic [BUS_AW-1:0] mem_off;
    logic              mem_hit;
    logic [SRC_AW-1:0] mem_idx;
    logic              hit_ctrl;

    assign mem_off  = reg_addr - BUS_AW'(MEM_BASE);
    assign mem_hit  = (reg_addr >= BUS_AW'(MEM_BASE))
                   && (mem_off[BUS_AW-1:2] < (BUS_AW-2)'(MEM_WORDS))
                   && (mem_off[1:0] == 2'b00);
    assign mem_idx  = mem_off[SRC_AW+1:2];
    assign hit_ctrl = (reg_addr == BUS_AW'(OFS_CTRL));

    // Copy configuration
    logic              arm_q;
    logic [SRC_AW-1:0] src_q;
    logic [IMEM_AW-1:0] dst_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy, done, go;

    assign go = !busy && ((reg_we && hit_ctrl && reg_wdata[BIT_GO])
                       || (pwr_up && arm_q));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (reg_we) begin
            if (hit_ctrl) arm_q <= reg_wdata[BIT_ARM];
            if (!busy) begin
                if (reg_addr == BUS_AW'(OFS_SRC)) src_q <= reg_wdata[SRC_AW-1:0];
                if (reg_addr == BUS_AW'(OFS_DST)) dst_q <= reg_wdata[IMEM_AW-1:0];
                if (reg_addr == BUS_AW'(OFS_CNT)) cnt_q <= reg_wdata[CNT_W-1:0];
            end
        end
    end

    // Bootstrap memory and sequencer
    logic [31:0]       bus_q, eng_q;
    logic [SRC_AW-1:0] eng_addr;

    boot_store #(
        .WORDS (MEM_WORDS),
        .AW    (SRC_AW)
    ) u_store (
        .clk       (clk),
        .bus_we    (reg_we && mem_hit),
        .bus_addr  (mem_idx),
        .bus_wdata (reg_wdata),
        .bus_q     (bus_q),
        .eng_addr  (eng_addr),
        .eng_q     (eng_q)
    );

    copy_sequencer #(
        .SRC_AW (SRC_AW),
        .DST_AW (IMEM_AW),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .src_base (src_q),
        .dst_base (dst_q),
        .count    (cnt_q),
        .rd_q     (eng_q),
        .busy     (busy),
        .done     (done),
        .rd_addr  (eng_addr),
        .wr_en    (imem_we),
        .wr_addr  (imem_addr),
        .wr_data  (imem_wdata)
    );

    image_regs #(
        .AW (BUS_AW)
    ) u_img (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_addr  (reg_addr),
        .wr_data  (reg_wdata),
        .inst_ptr (inst_ptr),
        .inst_len (inst_len),
        .data_ptr (data_ptr),
        .data_len (data_len),
        .load_req (load_req)
    );

    // Read path: registered, one cycle after the address
    logic [31:0] rd_val, rd_reg_q;
    logic        rd_mem_q;

    always_comb begin
        rd_val = '0;
        if (hit_ctrl) begin
            rd_val[BIT_GO]  = busy;
            rd_val[BIT_ARM] = arm_q;
        end else if (reg_addr == BUS_AW'(OFS_SRC)) begin
            rd_val[SRC_AW-1:0] = src_q;
        end else if (reg_addr == BUS_AW'(OFS_DST)) begin
            rd_val[IMEM_AW-1:0] = dst_q;
        end else if (reg_addr == BUS_AW'(OFS_CNT)) begin
            rd_val[CNT_W-1:0] = cnt_q;
        end else if (reg_addr == BUS_AW'(OFS_STAT)) begin
            rd_val[0] = done;
        end else if (reg_addr == BUS_AW'(OFS_IPTR)) begin
            rd_val = inst_ptr;
        end else if (reg_addr == BUS_AW'(OFS_ILEN)) begin
            rd_val[30:0] = inst_len;
        end else if (reg_addr == BUS_AW'(OFS_DPTR)) begin
            rd_val = data_ptr;
        end else if (reg_addr == BUS_AW'(OFS_DLEN)) begin
            rd_val = data_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_reg_q <= '0;
            rd_mem_q <= 1'b0;
        end else begin
            rd_reg_q <= rd_val;
            rd_mem_q <= mem_hit;
        end
    end

    assign reg_rdata = rd_mem_q ? bus_q : rd_reg_q;

    // R6: copy configuration holds still for the whole run
    assert_cfg_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(src_q) && $stable(dst_q) && $stable(cnt_q)));

    // R7: a power-up event without arm leaves the engine idle
    assert_pwrup_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_up && !arm_q && !busy && !(reg_we && hit_ctrl)) |=> !busy);

endmodule

// File: tb/test_boot_copy_engine.sv
module test_boot_copy_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_up = 1'b0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        imem_we;
    logic [11:0] imem_addr;
    logic [31:0] imem_wdata;
    logic        load_req;
    logic [31:0] inst_ptr, data_ptr, data_len;
    logic [30:0] inst_len;

    always #4 clk = ~clk;

    boot_copy_engine i_boot_copy_engine (
        .clk(clk), .rst_n(rst_n), .pwr_up(pwr_up),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .imem_we(imem_we), .imem_addr(imem_addr),
        .imem_wdata(imem_wdata), .load_req(load_req), .inst_ptr(inst_ptr),
        .inst_len(inst_len), .data_ptr(data_ptr), .data_len(data_len)
    );

    int vectors = 0;
    int fails   = 0;
    int wr_total = 0;
    int bursts = 0;
    int lreq_cycles = 0;
    logic prev_we = 1'b0;
    logic [31:0] imem_model [4096];

    // Monitor away from the active edge
    always @(negedge clk) begin
        if (imem_we) begin
            imem_model[imem_addr] = imem_wdata;
            wr_total++;
            if (!prev_we) bursts++;
        end
        prev_we = imem_we;
        if (load_req) lreq_cycles++;
    end

    function automatic logic [31:0] pat(int i);
        return 32'h1000_0001 + 32'(i) * 32'h0001_0003;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(int addr, logic [31:0] data);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 12'(addr); reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic bus_read(int addr, output logic [31:0] data);
        @(negedge clk);
        reg_addr = 12'(addr);
        @(negedge clk);
        data = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int k = 0; k < 2000; k++) begin
            bus_read('h0, v);
            if (!v[31]) return;
        end
    endtask

    task automatic pulse_pwr();
        @(negedge clk); pwr_up = 1'b1;
        @(negedge clk); pwr_up = 1'b0;
    endtask

    task automatic clear_model();
        for (int k = 0; k < 4096; k++) imem_model[k] = '0;
    endtask

    task automatic setup(int src, int dst, int cnt);
        bus_write('h4, 32'(src));
        bus_write('h8, 32'(dst));
        bus_write('hC, 32'(cnt));
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R10 imem_we", 32'(imem_we), 0);
        check("R10 load_req", 32'(load_req), 0);
        bus_read('h0, v);  check("R10 ctrl", v, 0);
        bus_read('h10, v); check("R10 status", v, 0);
        bus_read('h4, v);  check("R10 src", v, 0);
        bus_read('h94, v); check("R10 ilen", v, 0);
    endtask

    task automatic t_zero();
        logic [31:0] v;
        int w0;
        w0 = wr_total;
        setup(3, 'h50, 0);
        bus_write('h0, 32'h8000_0000);
        bus_read('h10, v); check("R5 done at once", v & 1, 1);
        bus_read('h0, v);  check("R5 go reads 0", v[31], 0);
        repeat (10) @(negedge clk);
        check("R5 no write", 32'(wr_total - w0), 0);
    endtask

    task automatic t_memory();
        logic [31:0] v;
        for (int k = 0; k < 256; k++) bus_write('h400 + 4 * k, pat(k));
        bus_read('h400, v); check("R1 word0", v, pat(0));
        bus_read('h404, v); check("R1 word1", v, pat(1));
        bus_read('h5FC, v); check("R1 word127", v, pat(127));
        bus_read('h7FC, v); check("R1 word255", v, pat(255));
    endtask

    task automatic t_copy();
        logic [31:0] v;
        int w0, b0;
        clear_model();
        setup(4, 'h100, 8);
        w0 = wr_total; b0 = bursts;
        bus_write('h0, 32'h8000_0000);
        bus_read('h0, v);  check("R4 go while busy", v[31], 1);
        bus_read('h10, v); check("R4 status while busy", v & 1, 0);
        wait_idle();
        bus_read('h10, v); check("R4 status done", v & 1, 1);
        check("R2 word count", 32'(wr_total - w0), 8);
        check("R3 one burst", 32'(bursts - b0), 1);
        for (int k = 0; k < 8; k++) check("R2 data", imem_model['h100 + k], pat(4 + k));
        check("R2 no overrun", imem_model['h108], 0);
        check("R2 no underrun", imem_model['hFF], 0);
    endtask

    task automatic t_wrap();
        int w0, b0;
        clear_model();
        setup(250, 'h200, 10);
        w0 = wr_total;
        bus_write('h0, 32'h8000_0000);
        wait_idle();
        check("R3 wrap count", 32'(wr_total - w0), 10);
        for (int k = 0; k < 10; k++) check("R3 wrap data", imem_model['h200 + k], pat((250 + k) % 256));
        setup(0, 'h300, 256);
        w0 = wr_total; b0 = bursts;
        bus_write('h0, 32'h8000_0000);
        wait_idle();
        check("R3 full count", 32'(wr_total - w0), 256);
        check("R3 full burst", 32'(bursts - b0), 1);
        check("R3 full first", imem_model['h300], pat(0));
        check("R3 full last", imem_model['h3FF], pat(255));
    endtask

    task automatic t_frozen();
        logic [31:0] v;
        int w0;
        clear_model();
        setup(0, 'h400, 64);
        w0 = wr_total;
        bus_write('h0, 32'h8000_0000);
        bus_write('h4, 9);
        bus_write('h8, 'h800);
        bus_write('hC, 3);
        wait_idle();
        bus_read('h4, v); check("R6 src kept", v, 0);
        bus_read('h8, v); check("R6 dst kept", v, 'h400);
        bus_read('hC, v); check("R6 cnt kept", v, 64);
        check("R6 count used", 32'(wr_total - w0), 64);
        check("R6 old dst", imem_model['h400], pat(0));
        check("R6 new dst untouched", imem_model['h800], 0);
    endtask

    task automatic t_pwrup();
        logic [31:0] v;
        int w0;
        clear_model();
        setup(16, 'h600, 5);
        bus_write('h0, 0);
        w0 = wr_total;
        pulse_pwr();
        repeat (20) @(negedge clk);
        check("R7 unarmed ignored", 32'(wr_total - w0), 0);
        bus_write('h0, 32'h4000_0000);
        bus_read('h0, v); check("R7 arm readback", v, 32'h4000_0000);
        pulse_pwr();
        wait_idle();
        check("R7 armed copy", 32'(wr_total - w0), 5);
        for (int k = 0; k < 5; k++) check("R7 armed data", imem_model['h600 + k], pat(16 + k));
        clear_model();
        pulse_pwr();
        wait_idle();
        check("R7 repeat copy", 32'(wr_total - w0), 10);
        check("R7 repeat data", imem_model['h604], pat(20));
        setup(0, 'hA00, 40);
        w0 = wr_total;
        pulse_pwr();
        repeat (5) @(negedge clk);
        pulse_pwr();
        wait_idle();
        repeat (10) @(negedge clk);
        check("R7 busy ignored", 32'(wr_total - w0), 40);
    endtask

    task automatic t_loader();
        logic [31:0] v;
        int l0;
        bus_write('h90, 32'h1234_5670);
        bus_write('h98, 32'hCAFE_0010);
        bus_write('h9C, 32'h0000_0800);
        check("R8 iptr out", inst_ptr, 32'h1234_5670);
        check("R8 dptr out", data_ptr, 32'hCAFE_0010);
        check("R8 dlen out", data_len, 32'h0000_0800);
        bus_read('h98, v); check("R8 dptr read", v, 32'hCAFE_0010);
        l0 = lreq_cycles;
        bus_write('h94, 32'h0000_4000);
        repeat (3) @(negedge clk);
        check("R9 no flag no pulse", 32'(lreq_cycles - l0), 0);
        check("R8 ilen out", 32'(inst_len), 32'h4000);
        bus_write('h94, 32'h8000_2000);
        check("R9 pulse cycle", 32'(load_req), 1);
        @(negedge clk);
        check("R9 pulse ends", 32'(load_req), 0);
        repeat (3) @(negedge clk);
        check("R9 single cycle", 32'(lreq_cycles - l0), 1);
        check("R8 ilen low bits", 32'(inst_len), 32'h2000);
        bus_read('h94, v); check("R8 ilen flag reads 0", v, 32'h0000_2000);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        clear_model();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_zero();
        t_memory();
        t_copy();
        t_wrap();
        t_frozen();
        t_pwrup();
        t_loader();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule